// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the small set of control registers that sits behind the register bus of a stereo audio codec. A host addresses the bus with a 7-bit index and has a write strobe with 16-bit write data and a read strobe. Read data comes back on a 16-bit port one clock after the read strobe. The block holds four things:

- a fixed identification word that is also the soft-reset trigger;
- the stereo master output volume with its mute bits;
- a split-mute enable;
- a serial-configuration word that a soft reset does not clear.

The volume register keeps a host that writes 6-bit volume fields compatible. When the sixth bit of a channel field is written as 1, the 5-bit attenuation of that channel saturates to its maximum. A per-channel right mute exists only while split-mute is enabled. Otherwise that bit reads 0, and writing it has no effect.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After the active-low synchronous reset `rst_n`, reads return these values: index 0x02 returns 0x8000, index 0x76 returns 0x0000 and index 0x74 returns 0x0000. `rd_data` is 0x0000 before the first read.
- R2: A read of index 0x00 always returns 0x0090. Bits 14:10 (stereo-enhancement code) are 0. Bit 4 (headphone output) and bit 7 (20-bit DAC) are 1. All other bits are 0.
- R3: `rd_data` takes its new value on the clock edge where `rd_en` is sampled high. It holds that value until the next read, whatever writes happen in between.
- R4: A read of any index other than 0x00, 0x02, 0x74 and 0x76 returns 0x0000.
- R5: The fields of index 0x02 are: bit 15 mutes both channels, bits 12:8 are the left attenuation and bits 4:0 are the right attenuation. Bits 13 and 5 read back as written. Bits 14 and 6 always read 0.
- R6: A write to 0x02 with bit 13 set stores 0x1F in bits 12:8, whatever data was supplied. A write with bit 5 set stores 0x1F in bits 4:0.
- R7: Index 0x76 bit 0 is the split-mute enable, with default 0. Its other bits read 0.
- R8: Bit 7 of 0x02 (right mute) reads as the stored bit while split-mute is 1 and reads 0 while split-mute is 0. A write to 0x02 while split-mute is 0 leaves the stored right-mute bit unchanged.
- R9: A write of any data to index 0x00 returns 0x02 and 0x76 to their defaults on that write's clock edge. A read strobed on the very next cycle returns the defaults.
- R10: Index 0x74 stores all 16 written bits and keeps them through a soft reset. Only `rst_n` clears it to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset, loads every default |
| reg_idx | input | 7 | Register index for the current access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 16 | Data written at `reg_idx` |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |

## Verification
The assertions assume that the host never raises `wr_en` and `rd_en` in the same cycle. They also assume that the index, data and strobes are stable around the rising edge. The stimulus keeps to this by driving every input on the falling edge and by giving each access its own cycle. The strobes are dropped again before the next access. The properties on the split-mute gating and on soft reset also assume that only one index is written per cycle, which follows from the single-index bus.

// File: rtl/codec_regs_pkg.sv
// Package: codec_regs_pkg
// Shared widths, register indices, default values and the stored layout of
// the master volume register. Assumes a 7-bit index and 16-bit data bus.
package codec_regs_pkg;

    localparam int IDX_W  = 7;
    localparam int DATA_W = 16;
    localparam int VOL_W  = 5;

    localparam logic [IDX_W-1:0] IDX_IDENT  = 7'h00;
    localparam logic [IDX_W-1:0] IDX_MVOL   = 7'h02;
    localparam logic [IDX_W-1:0] IDX_SERCFG = 7'h74;
    localparam logic [IDX_W-1:0] IDX_SPLIT  = 7'h76;

    localparam logic [DATA_W-1:0] IDENT_WORD   = 16'h0090;
    localparam logic [DATA_W-1:0] MVOL_DEFAULT = 16'h8000;
    localparam logic [DATA_W-1:0] SERCFG_INIT  = 16'h0000;

    // Stored bits of the master volume register (reserved bits omitted)
    typedef struct packed {
        logic             mute_both;
        logic             left_ext;
        logic [VOL_W-1:0] left_att;
        logic             right_mute;
        logic             right_ext;
        logic [VOL_W-1:0] right_att;
    } mvol_t;

endpackage

// File: rtl/cc_index_decode.sv
// Module: cc_index_decode
// Turns a write strobe and index into one write-enable per register and the
// soft-reset pulse. Assumes at most one access per cycle.
module cc_index_decode
    import codec_regs_pkg::*;
(
    input  logic             wr_en,
    input  logic [IDX_W-1:0] reg_idx,
    output logic             soft_rst,
    output logic             we_mvol,
    output logic             we_split,
    output logic             we_sercfg
);

    // Purpose: one-hot decode of the written index
    always_comb begin
        soft_rst  = wr_en && (reg_idx == IDX_IDENT);
        we_mvol   = wr_en && (reg_idx == IDX_MVOL);
        we_split  = wr_en && (reg_idx == IDX_SPLIT);
        we_sercfg = wr_en && (reg_idx == IDX_SERCFG);
    end

endmodule

// File: rtl/cc_field_reg.sv
// Module: cc_field_reg
// Plain storage register of parameter width. Hard reset loads INIT_VAL.
// When KEEP_ON_SOFT is 0, soft reset also loads INIT_VAL. When it is 1,
// the value survives soft reset. Assumes we and soft_rst are never both high.
module cc_field_reg #(
    parameter int          W            = 16,
    parameter logic [W-1:0] INIT_VAL    = '0,
    parameter bit          KEEP_ON_SOFT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (KEEP_ON_SOFT) begin : g_keep
            // Purpose: storage that ignores soft reset
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= INIT_VAL;
                else if (we) q <= d;
            end

            // R10
            keep_on_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (soft_rst && !we) |=> $stable(q));
        end else begin : g_clear
            // Purpose: storage returned to its initial value by soft reset
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= INIT_VAL;
                else if (soft_rst) q <= INIT_VAL;
                else if (we)       q <= d;
            end

            // R9
            clear_on_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
                soft_rst |=> (q == INIT_VAL));
        end
    endgenerate

endmodule

// File: rtl/cc_master_volume.sv
// Module: cc_master_volume
// Master volume register. A write with a channel's extension bit set
// saturates that channel's attenuation. The right-mute bit is written and
// shown only while split_en is 1. Assumes we and soft_rst are exclusive.
module cc_master_volume
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              split_en,
    output logic [DATA_W-1:0] rd_word
);

    localparam mvol_t DEF_STORE = '{mute_both: MVOL_DEFAULT[15], left_ext: MVOL_DEFAULT[13],
                                    left_att: MVOL_DEFAULT[12:8], right_mute: MVOL_DEFAULT[7],
                                    right_ext: MVOL_DEFAULT[5], right_att: MVOL_DEFAULT[4:0]};

    mvol_t            st;
    logic [VOL_W-1:0] left_next;
    logic [VOL_W-1:0] right_next;

    // Purpose: compatibility saturation of each written attenuation field
    always_comb begin
        left_next  = wdata[13] ? '1 : wdata[12:8];
        right_next = wdata[5]  ? '1 : wdata[4:0];
    end

    // Purpose: stored volume state with hard and soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st <= DEF_STORE;
        end else if (we) begin
            st.mute_both <= wdata[15];
            st.left_ext  <= wdata[13];
            st.left_att  <= left_next;
            st.right_ext <= wdata[5];
            st.right_att <= right_next;
            if (split_en) st.right_mute <= wdata[7];
        end
    end

    // Purpose: readback word with reserved bits at 0 and gated right mute
    always_comb begin
        rd_word = {st.mute_both, 1'b0, st.left_ext, st.left_att,
                   st.right_mute & split_en, 1'b0, st.right_ext, st.right_att};
    end

    // R6
    left_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[13]) |=> (st.left_att == '1));

    // R6
    right_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[5]) |=> (st.right_att == '1));

    // R8
    rmute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_en && !soft_rst) |=> $stable(st.right_mute));

    // R9
    soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rd_word == MVOL_DEFAULT));

endmodule

// File: rtl/cc_read_port.sv
// Module: cc_read_port
// Registered read path. It selects the word for the strobed index and holds
// it until the next read. Unknown indices return zero.
module cc_read_port
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] mvol_word,
    input  logic              split_q,
    input  logic [DATA_W-1:0] sercfg_q,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] sel_word;

    // Purpose: index to read word selection
    always_comb begin
        case (reg_idx)
            IDX_IDENT:  sel_word = IDENT_WORD;
            IDX_MVOL:   sel_word = mvol_word;
            IDX_SPLIT:  sel_word = {{(DATA_W-1){1'b0}}, split_q};
            IDX_SERCFG: sel_word = sercfg_q;
            default:    sel_word = '0;
        endcase
    end

    // Purpose: capture the selected word on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end

    // R2
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == IDX_IDENT) |=> (rd_data == 16'h0090));

    // R4
    unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx != IDX_IDENT && reg_idx != IDX_MVOL &&
         reg_idx != IDX_SPLIT && reg_idx != IDX_SERCFG) |=> (rd_data == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/codec_ctrl_regs.sv
// Module: codec_ctrl_regs
// Top of the codec control register file. It ties the index decode, the
// master volume, the split-mute and serial-configuration storage and the
// registered read port together. Assumes one bus access per cycle.
module codec_ctrl_regs
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    logic              soft_rst;
    logic              we_mvol;
    logic              we_split;
    logic              we_sercfg;
    logic              split_q;
    logic [DATA_W-1:0] sercfg_q;
    logic [DATA_W-1:0] mvol_word;

    cc_index_decode u_dec (
        .wr_en     (wr_en),
        .reg_idx   (reg_idx),
        .soft_rst  (soft_rst),
        .we_mvol   (we_mvol),
        .we_split  (we_split),
        .we_sercfg (we_sercfg)
    );

    cc_field_reg #(.W(1), .INIT_VAL(1'b0), .KEEP_ON_SOFT(1'b0)) u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (we_split),
        .d        (wr_data[0]),
        .q        (split_q)
    );

    cc_field_reg #(.W(DATA_W), .INIT_VAL(SERCFG_INIT), .KEEP_ON_SOFT(1'b1)) u_sercfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (we_sercfg),
        .d        (wr_data),
        .q        (sercfg_q)
    );

    cc_master_volume u_mvol (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (we_mvol),
        .wdata    (wr_data),
        .split_en (split_q),
        .rd_word  (mvol_word)
    );

    cc_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .reg_idx   (reg_idx),
        .mvol_word (mvol_word),
        .split_q   (split_q),
        .sercfg_q  (sercfg_q),
        .rd_data   (rd_data)
    );

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

endmodule

// File: tb/codec_ctrl_regs_test.sv
// Bench for codec_ctrl_regs: a vector table walked by one loop, then
// directed tests of read hold, back-to-back soft reset and hardware reset.
module codec_ctrl_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 34;

    // {req[3:0], is_write, idx[6:0], data[15:0], expect[15:0]}
    localparam logic [43:0] VEC [NVEC] = '{
        {4'd2,  1'b0, 7'h00, 16'h0000, 16'h0090}, // R2 ident
        {4'd1,  1'b0, 7'h02, 16'h0000, 16'h8000}, // R1 volume default
        {4'd1,  1'b0, 7'h76, 16'h0000, 16'h0000}, // R1 split default
        {4'd1,  1'b0, 7'h74, 16'h0000, 16'h0000}, // R1 serial default
        {4'd5,  1'b1, 7'h02, 16'h1A0C, 16'h0000}, // R5 plain fields
        {4'd5,  1'b0, 7'h02, 16'h0000, 16'h1A0C},
        {4'd6,  1'b1, 7'h02, 16'hFFFF, 16'h0000}, // R6 both saturate, R5 reserved 0, R8 hidden
        {4'd6,  1'b0, 7'h02, 16'h0000, 16'hBF3F},
        {4'd6,  1'b1, 7'h02, 16'h2005, 16'h0000}, // R6 left only
        {4'd6,  1'b0, 7'h02, 16'h0000, 16'h3F05},
        {4'd6,  1'b1, 7'h02, 16'h0021, 16'h0000}, // R6 right only
        {4'd6,  1'b0, 7'h02, 16'h0000, 16'h003F},
        {4'd7,  1'b1, 7'h76, 16'hFFFF, 16'h0000}, // R7 only bit 0
        {4'd7,  1'b0, 7'h76, 16'h0000, 16'h0001},
        {4'd8,  1'b1, 7'h02, 16'h8080, 16'h0000}, // R8 split on, right mute stored
        {4'd8,  1'b0, 7'h02, 16'h0000, 16'h8080},
        {4'd8,  1'b1, 7'h76, 16'h0000, 16'h0000}, // R8 split off hides it
        {4'd8,  1'b0, 7'h02, 16'h0000, 16'h8000},
        {4'd8,  1'b1, 7'h02, 16'h0000, 16'h0000}, // R8 write while off
        {4'd8,  1'b1, 7'h76, 16'h0001, 16'h0000},
        {4'd8,  1'b0, 7'h02, 16'h0000, 16'h0080}, // R8 stored bit unchanged
        {4'd10, 1'b1, 7'h74, 16'hA5C3, 16'h0000}, // R10 full word
        {4'd10, 1'b0, 7'h74, 16'h0000, 16'hA5C3},
        {4'd4,  1'b0, 7'h13, 16'h0000, 16'h0000}, // R4 unknown
        {4'd4,  1'b0, 7'h7F, 16'h0000, 16'h0000}, // R4 unknown
        {4'd4,  1'b0, 7'h04, 16'h0000, 16'h0000}, // R4 unknown
        {4'd9,  1'b1, 7'h00, 16'h1234, 16'h0000}, // R9 soft reset
        {4'd9,  1'b0, 7'h02, 16'h0000, 16'h8000},
        {4'd9,  1'b0, 7'h76, 16'h0000, 16'h0000},
        {4'd10, 1'b0, 7'h74, 16'h0000, 16'hA5C3}, // R10 survives
        {4'd2,  1'b0, 7'h00, 16'h0000, 16'h0090}, // R2 unchanged by write
        {4'd8,  1'b1, 7'h02, 16'h0080, 16'h0000}, // R8 split default 0
        {4'd8,  1'b1, 7'h76, 16'h0001, 16'h0000},
        {4'd8,  1'b0, 7'h02, 16'h0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_idx = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;

    int total = 0;
    int bad   = 0;

    codec_ctrl_regs uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] idx, input logic [15:0] d);
        @(negedge clk);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] idx, output logic [15:0] d);
        @(negedge clk);
        reg_idx = idx; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: read data is zero straight after reset
        check(1, rd_data, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][39]) begin
                bus_write(VEC[i][38:32], VEC[i][31:16]);
            end else begin
                bus_read(VEC[i][38:32], r);
                check(int'(VEC[i][43:40]), r, VEC[i][15:0]);
            end
        end

        // R3: read data holds through idle cycles and writes
        bus_read(7'h74, r);
        repeat (3) @(negedge clk);
        check(3, rd_data, 16'hA5C3);
        bus_write(7'h74, 16'h0F0F);
        check(3, rd_data, 16'hA5C3);
        bus_read(7'h74, r);
        check(3, r, 16'h0F0F);

        // R9: read on the cycle right after the soft-reset write
        bus_write(7'h02, 16'h1111);
        @(negedge clk);
        reg_idx = 7'h00; wr_data = 16'hFFFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; reg_idx = 7'h02; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(9, rd_data, 16'h8000);

        // R10 / R1: hardware reset clears serial configuration
        bus_write(7'h02, 16'h0404);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, rd_data, 16'h0000);
        bus_read(7'h74, r);
        check(10, r, 16'h0000);
        bus_read(7'h02, r);
        check(1, r, 16'h8000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule